// File: doc/BRIEF.md
# Framebuffer SRAM Controller with Byte Read-Modify-Write

The controller owns a 16-bit asynchronous static RAM that holds an 8-bit-per-pixel frame buffer. It runs a fixed four-cycle slot schedule. Each period has a guaranteed word read for video scanout, so the 40 MHz pixel stream gets one byte every second cycle of the 80 MHz controller clock. The other slots serve byte writes of computed pixels. The memory has no per-byte write enables, so each byte write becomes a read of the word, a merge of the new byte into its upper or lower half, and a write back of the whole word.

The scanout address counts up by one word per period. A frame-start pulse reloads it from a programmable base word address, which lets the view scroll. Write requests arrive through a valid/ready pair, at most one per period. The block drives the chip enable, output enable, write enable, address, outgoing data and the output enable of the data bus driver. It takes the returned data on a separate input.

Top module: `sram_fb_ctrl`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `sram_ce_n`, `sram_oe_n` and `sram_we_n` are high, `sram_dq_oe` and `pix_stb` are low, and `wr_ready` is high.
- R2: The first clock edge after reset release begins slot 0. Slots then repeat 0,1,2,3 every four cycles: slot 0 is the update read, slot 1 the display read, slot 2 the write and slot 3 turnaround. Every slot 1 reads, with `sram_ce_n` and `sram_oe_n` low and `sram_we_n` high.
- R3: For the word read in slot 1, `pix_stb` is high in the next cycle (slot 2) with `pix_byte` equal to bits [7:0]. It is high again in the following slot 0 with bits [15:8]. `pix_stb` is low in slots 1 and 3, and no strobe occurs before the first display read.
- R4: The display read address rises by one word per period and wraps at the top of the address space. If `frame_start` is sampled high at an edge, the next display read uses the `fb_base` sampled at that edge.
- R5: A byte write goes to word `wr_addr[AW:1]`. `wr_addr[0]`=0 replaces bits [7:0] and `wr_addr[0]`=1 replaces bits [15:8]. The other byte keeps the value read from that word in slot 0 of the same period.
- R6: In a write slot, `sram_we_n` is low for that one cycle with `sram_ce_n` low, `sram_oe_n` high and `sram_dq_oe` high. The word address and the merged word sit on `sram_addr` and `sram_dq_o`.
- R7: `sram_dq_oe` is high only in a write slot and is low in the following slot 3. It is never high while `sram_oe_n` is low.
- R8: `wr_ready` is high exactly when no request is pending. A request accepted at edge E is served in the first period whose slot 0 begins at E or later. `wr_ready` stays low from acceptance until the edge that ends that write slot.
- R9: A period with no request served leaves `sram_ce_n`, `sram_oe_n` and `sram_we_n` high and `sram_dq_oe` low in slots 0 and 2, while the display read in slot 1 is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous reset, active high |
| fb_base | input | AW | Word address where scanout restarts on a frame start |
| frame_start | input | 1 | One-cycle pulse that reloads the scanout address |
| wr_valid | input | 1 | Byte write request present |
| wr_ready | output | 1 | Request accepted on this edge when valid is also high |
| wr_addr | input | AW+1 | Byte address; bit 0 selects the half of the word |
| wr_byte | input | 8 | Pixel value to store |
| pix_byte | output | 8 | Pixel value for the video path |
| pix_stb | output | 1 | `pix_byte` holds a new pixel this cycle |
| sram_addr | output | AW | Memory word address |
| sram_ce_n | output | 1 | Chip enable, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_we_n | output | 1 | Write enable, active low |
| sram_dq_o | output | 16 | Data driven toward the memory |
| sram_dq_oe | output | 1 | Enables the data bus output driver |
| sram_dq_i | input | 16 | Data returned by the memory |

## Verification
The assertions take for granted two things about the inputs. The memory returns valid read data within the same cycle that `sram_ce_n` and `sram_oe_n` are low. `frame_start` is a pulse and not a level held across a display read. The bench's memory model answers combinationally from the address and enables, and it writes on the clock edge that ends a low `sram_we_n`. The stimulus drives every input at the falling edge and pulses `frame_start` for exactly one cycle. Write requests hold steady until they are accepted, with random gaps, random byte addresses and back-to-back hits on the same word.

// File: rtl/sram_fb_ctrl.sv
module sram_fb_ctrl #(
  parameter int AW = 18
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] fb_base,
  input  logic          frame_start,
  input  logic          wr_valid,
  output logic          wr_ready,
  input  logic [AW:0]   wr_addr,
  input  logic [7:0]    wr_byte,
  output logic [7:0]    pix_byte,
  output logic          pix_stb,
  output logic [AW-1:0] sram_addr,
  output logic          sram_ce_n,
  output logic          sram_oe_n,
  output logic          sram_we_n,
  output logic [15:0]   sram_dq_o,
  output logic          sram_dq_oe,
  input  logic [15:0]   sram_dq_i
);

  logic [1:0]    ph;
  logic          pend, busy, hi_q, have_w;
  logic [AW-1:0] wa_q, disp_ptr;
  logic [7:0]    wb_q;
  logic [15:0]   mrg, hold;

  wire           take = pend | wr_valid;
  wire [AW-1:0]  cur  = frame_start ? fb_base : disp_ptr;

  assign wr_ready = ~pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph <= 2'd3;
      pend <= 1'b0;
      busy <= 1'b0;
      hi_q <= 1'b0;
      have_w <= 1'b0;
      wa_q <= '0;
      wb_q <= '0;
      disp_ptr <= '0;
      mrg <= '0;
      hold <= '0;
      pix_byte <= '0;
      pix_stb <= 1'b0;
      sram_addr <= '0;
      sram_ce_n <= 1'b1;
      sram_oe_n <= 1'b1;
      sram_we_n <= 1'b1;
      sram_dq_o <= '0;
      sram_dq_oe <= 1'b0;
    end else begin
      ph <= ph + 2'd1;
      pix_stb <= 1'b0;
      sram_ce_n <= 1'b1;
      sram_oe_n <= 1'b1;
      sram_we_n <= 1'b1;
      sram_dq_oe <= 1'b0;
      if (wr_valid && !pend) begin
        pend <= 1'b1;
        wa_q <= wr_addr[AW:1];
        hi_q <= wr_addr[0];
        wb_q <= wr_byte;
      end
      if (ph != 2'd0 && frame_start) disp_ptr <= fb_base;
      case (ph)
        2'd3: begin
          busy <= take;
          if (take) begin
            sram_ce_n <= 1'b0;
            sram_oe_n <= 1'b0;
            sram_addr <= pend ? wa_q : wr_addr[AW:1];
          end
          if (have_w) begin
            pix_byte <= hold[15:8];
            pix_stb <= 1'b1;
          end
        end
        2'd0: begin
          if (busy) mrg <= hi_q ? {wb_q, sram_dq_i[7:0]} : {sram_dq_i[15:8], wb_q};
          sram_ce_n <= 1'b0;
          sram_oe_n <= 1'b0;
          sram_addr <= cur;
          disp_ptr <= cur + 1'b1;
        end
        2'd1: begin
          hold <= sram_dq_i;
          have_w <= 1'b1;
          pix_byte <= sram_dq_i[7:0];
          pix_stb <= 1'b1;
          if (busy) begin
            sram_ce_n <= 1'b0;
            sram_we_n <= 1'b0;
            sram_dq_oe <= 1'b1;
            sram_addr <= wa_q;
            sram_dq_o <= mrg;
          end
        end
        2'd2: begin
          if (busy) pend <= 1'b0;
          busy <= 1'b0;
        end
      endcase
    end
  end

  p_disp_slot_r2: assert property (@(posedge clk) disable iff (rst)
    (ph == 2'd1) |-> (!sram_ce_n && !sram_oe_n && sram_we_n));

  p_stb_gap_r3: assert property (@(posedge clk) disable iff (rst)
    pix_stb |=> !pix_stb);

  p_write_slot_r6: assert property (@(posedge clk) disable iff (rst)
    !sram_we_n |-> (sram_oe_n && !sram_ce_n && sram_dq_oe && ph == 2'd2));

  p_release_r7: assert property (@(posedge clk) disable iff (rst)
    sram_dq_oe |=> !sram_dq_oe);

  p_no_drive_read_r7: assert property (@(posedge clk) disable iff (rst)
    !sram_oe_n |-> !sram_dq_oe);

  p_ready_drop_r8: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && wr_ready) |=> !wr_ready);

  p_idle_write_r9: assert property (@(posedge clk) disable iff (rst)
    (ph == 2'd2 && sram_we_n) |-> (sram_ce_n && sram_oe_n && !sram_dq_oe));

endmodule

// File: tb/sram_fb_ctrl_test.sv
module sram_fb_ctrl_test;
  localparam int AW = 10;
  localparam int NW = 1 << AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [AW-1:0] fb_base = '0;
  logic frame_start = 1'b0;
  logic wr_valid = 1'b0;
  logic wr_ready;
  logic [AW:0] wr_addr = '0;
  logic [7:0] wr_byte = '0;
  logic [7:0] pix_byte;
  logic pix_stb;
  logic [AW-1:0] sram_addr;
  logic sram_ce_n, sram_oe_n, sram_we_n, sram_dq_oe;
  logic [15:0] sram_dq_o, sram_dq_i;

  always #4 clk = ~clk;

  sram_fb_ctrl #(.AW(AW)) uut (
    .clk(clk), .rst(rst), .fb_base(fb_base), .frame_start(frame_start),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_byte(wr_byte),
    .pix_byte(pix_byte), .pix_stb(pix_stb), .sram_addr(sram_addr),
    .sram_ce_n(sram_ce_n), .sram_oe_n(sram_oe_n), .sram_we_n(sram_we_n),
    .sram_dq_o(sram_dq_o), .sram_dq_oe(sram_dq_oe), .sram_dq_i(sram_dq_i)
  );

  function automatic logic [15:0] initv(int i);
    return 16'(i * 40503) ^ 16'h5A5A;
  endfunction

  function automatic logic [15:0] merge(logic [15:0] w, logic hi, logic [7:0] b);
    return hi ? {b, w[7:0]} : {w[15:8], b};
  endfunction

  logic [15:0] mem [NW];
  logic [15:0] refm [NW];

  assign sram_dq_i = (!sram_ce_n && !sram_oe_n) ? mem[sram_addr] : 16'hDEAD;

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NW; i++) mem[i] <= initv(i);
    end else if (!sram_ce_n && !sram_we_n && sram_dq_oe) begin
      mem[sram_addr] <= sram_dq_o;
    end
  end

  int nchk = 0, nfail = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] got, input logic [31:0] expv);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s got %h expected %h at %0t", tag, got, expv, $time);
    end
  endtask

  int bslot = -1;
  bit exp_pend = 0, active = 0, rdy_s = 1, have_w = 0;
  logic [AW:0] ea;
  logic [7:0] ed;
  logic [AW-1:0] exp_ptr = '0;
  logic [15:0] rmw_rd, lastw;

  always @(posedge clk) begin
    if (rst) begin
      bslot = -1;
      exp_pend = 0;
      active = 0;
      exp_ptr = '0;
      for (int i = 0; i < NW; i++) refm[i] = initv(i);
    end else begin
      if (bslot == 2) begin
        if (active) exp_pend = 0;
        active = 0;
      end
      if (wr_valid && rdy_s) begin
        exp_pend = 1;
        ea = wr_addr;
        ed = wr_byte;
        refm[wr_addr[AW:1]] = merge(refm[wr_addr[AW:1]], wr_addr[0], wr_byte);
      end
      bslot = (bslot + 1) % 4;
      if (bslot == 0 && exp_pend) active = 1;
      if (frame_start) exp_ptr = fb_base;
    end
  end

  always @(negedge clk) begin
    rdy_s = wr_ready;
    if (!rst && bslot >= 0) begin
      chk(wr_ready == !exp_pend, "R8 wr_ready", 32'(wr_ready), 32'(!exp_pend));
      case (bslot)
        0: begin
          if (active) begin
            chk(!sram_ce_n && !sram_oe_n && sram_we_n && !sram_dq_oe, "R2 update read ctl",
                {sram_ce_n, sram_oe_n, sram_we_n, sram_dq_oe}, 4'b0010);
            chk(sram_addr == ea[AW:1], "R5 update read addr", 32'(sram_addr), 32'(ea[AW:1]));
            rmw_rd = mem[sram_addr];
          end else begin
            chk(sram_ce_n && sram_oe_n && sram_we_n && !sram_dq_oe, "R9 idle slot0",
                {sram_ce_n, sram_oe_n, sram_we_n, sram_dq_oe}, 4'b1110);
          end
          if (have_w)
            chk(pix_stb && pix_byte == lastw[15:8], "R3 high byte", {pix_stb, pix_byte}, {1'b1, lastw[15:8]});
          else
            chk(!pix_stb, "R3 no early strobe", 32'(pix_stb), 0);
        end
        1: begin
          chk(!sram_ce_n && !sram_oe_n && sram_we_n && !sram_dq_oe, "R2 display read ctl",
              {sram_ce_n, sram_oe_n, sram_we_n, sram_dq_oe}, 4'b0010);
          chk(sram_addr == exp_ptr, "R4 display addr", 32'(sram_addr), 32'(exp_ptr));
          chk(!pix_stb, "R3 strobe low slot1", 32'(pix_stb), 0);
          lastw = mem[sram_addr];
          have_w = 1;
          exp_ptr = exp_ptr + 1'b1;
        end
        2: begin
          if (active) begin
            chk(!sram_ce_n && sram_oe_n && !sram_we_n && sram_dq_oe, "R6 write ctl",
                {sram_ce_n, sram_oe_n, sram_we_n, sram_dq_oe}, 4'b0101);
            chk(sram_addr == ea[AW:1], "R6 write addr", 32'(sram_addr), 32'(ea[AW:1]));
            chk(sram_dq_o == merge(rmw_rd, ea[0], ed), "R5 merged word",
                32'(sram_dq_o), 32'(merge(rmw_rd, ea[0], ed)));
          end else begin
            chk(sram_ce_n && sram_oe_n && sram_we_n && !sram_dq_oe, "R9 idle slot2",
                {sram_ce_n, sram_oe_n, sram_we_n, sram_dq_oe}, 4'b1110);
          end
          chk(pix_stb && pix_byte == lastw[7:0], "R3 low byte", {pix_stb, pix_byte}, {1'b1, lastw[7:0]});
        end
        default: begin
          chk(sram_ce_n && sram_oe_n && sram_we_n && !sram_dq_oe, "R7 turnaround",
              {sram_ce_n, sram_oe_n, sram_we_n, sram_dq_oe}, 4'b1110);
          chk(!pix_stb, "R3 strobe low slot3", 32'(pix_stb), 0);
        end
      endcase
    end
  end

  task automatic wr(input logic [AW:0] a, input logic [7:0] d);
    wr_valid = 1'b1;
    wr_addr = a;
    wr_byte = d;
    while (!wr_ready) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic pulse_frame(input logic [AW-1:0] b);
    wr_valid = 1'b0;
    fb_base = b;
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
  endtask

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    chk(sram_ce_n && sram_oe_n && sram_we_n && !sram_dq_oe, "R1 reset bus",
        {sram_ce_n, sram_oe_n, sram_we_n, sram_dq_oe}, 4'b1110);
    chk(!pix_stb && wr_ready, "R1 reset strobe/ready", {pix_stb, wr_ready}, 2'b01);
    rst = 1'b0;
    repeat (12) @(negedge clk);
    pulse_frame(10'h3FC);
    repeat (10) @(negedge clk);
    wr(11'h010, 8'hA1);
    wr(11'h011, 8'hB2);
    wr(11'h011, 8'hC3);
    wr(11'h7FF, 8'h44);
    wr_valid = 1'b0;
    repeat (9) @(negedge clk);
    wr(11'h020, 8'h5E);
    pulse_frame(10'h008);
    repeat (8) @(negedge clk);
    for (int n = 0; n < 600; n++) begin
      int g;
      logic [AW:0] a;
      g = $urandom % 4;
      if (g == 3) begin
        wr_valid = 1'b0;
        repeat ($urandom % 6) @(negedge clk);
      end
      if ($urandom % 24 == 0) pulse_frame(AW'($urandom));
      a = ($urandom % 3 == 0) ? 11'(12'h040 + $urandom % 4) : 11'($urandom);
      wr(a, 8'($urandom));
    end
    wr_valid = 1'b0;
    repeat (16) @(negedge clk);
    for (int i = 0; i < NW; i++)
      chk(mem[i] === refm[i], "R5 final memory word", 32'(mem[i]), 32'(refm[i]));
    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL R2 watchdog expired got 0 expected 1");
      summary();
      $finish;
    end
  end
endmodule